// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 32-bit physical address by reading translation entries from memory. A walk starts from the frame number of the top-level directory. The walker reads one directory entry and, for a small (4 KB) page, one table entry. For a large (4 MB) page the directory entry is the last level, and no table entry is read.

Each level is checked for presence, user access and write access. The walker sets the accessed flag on every successful walk and sets the dirty flag on writes. It writes an updated entry back to memory only when a flag actually changes.

Requests use a valid/busy handshake, with one walk in flight at a time. Memory is reached through a simple port that allows one access at a time. Each access holds its request until the memory acknowledges it. The result of a walk is a one-cycle `done` or `fault` pulse. With it come the physical address, the final entry and, on a fault, a cause code.

Top module: `pgwalk`

## Requirements
- R1: The directory entry is read at byte address {dir_frame, vaddr[31:22], 2'b00}. When that entry is updated, the new value is written to the same address.
- R2: When the directory entry has bit 7 = 0 (4 KB page), the table entry is read at {dir_entry[31:12], vaddr[21:12], 2'b00}. Any table write-back goes to the same address.
- R3: For a 4 KB page, `pa` = {table_entry[31:12], vaddr[11:0]}.
- R4: For a 4 MB page (directory bit 7 = 1), `pa` = {dir_entry[31:22], vaddr[21:0]}, and no table entry is read.
- R5: If bit 0 (present) of the entry being checked is 0, the walk ends with `fault` and `fault_cause` = 1. It reads nothing further and writes nothing at that level. On any fault `pa` is 0, and `fault_cause` is 0 in every cycle without `fault`.
- R6: For a user request, an entry whose bit 2 is 0 ends the walk with `fault_cause` = 2. Not-present takes priority over this cause.
- R7: For a write request, an entry whose bit 1 is 0 ends the walk with `fault_cause` = 3. This applies to supervisor requests too. Causes 1 and 2 take priority over it.
- R8: The accessed flag (bit 5) is set at every level that passes its checks. That level is written back only when bit 5 was 0 before.
- R9: The dirty flag (bit 6) of the table entry is set only by write requests. Accessed and dirty go back together in a single write, and only if the entry changed.
- R10: A request is taken when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the cycle of the one-cycle `done` or `fault` pulse, in which it is low. Request inputs are ignored while `busy` is high.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. `mem_rdata` is taken in the cycle of `mem_ack`.
- R12: `leaf_entry` gives the final entry with its updated flags, or the faulting entry exactly as read. Bits 3, 4 and 11:9 pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user mode access |
| dir_frame | input | 20 | Frame number of the page directory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished without fault (one cycle) |
| fault | output | 1 | Walk finished with fault (one cycle) |
| fault_cause | output | 2 | 1 not present, 2 user denied, 3 write denied |
| pa | output | 32 | Physical address of the last finished walk |
| leaf_entry | output | 32 | Final or faulting entry of the last walk |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access to memory |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The properties assume that memory raises `mem_ack` for exactly one cycle, and only while `mem_req` is high. They also assume that `mem_rdata` does not matter outside that cycle. The bench memory follows this rule. It answers after zero or one wait cycles, drops the acknowledge on the next edge, and starts no new access in the cycle of an acknowledge.

The sweep covers every combination of the directory flags (present, write, user, accessed, size), the table flags (present, write, user, accessed, dirty) and the request kind. During each walk the request inputs are driven to inverted values, so that any leak of them into the walk shows up.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  // entry flag positions; the walker decodes these
  localparam int unsigned FLG_PRESENT = 0;
  localparam int unsigned FLG_WRITE   = 1;
  localparam int unsigned FLG_USER    = 2;
  localparam int unsigned FLG_ACCESS  = 5;
  localparam int unsigned FLG_DIRTY   = 6;
  localparam int unsigned FLG_LARGE   = 7;

  typedef enum logic [2:0] {
    WS_IDLE   = 3'd0,
    WS_DIR_RD = 3'd1,
    WS_DIR_WB = 3'd2,
    WS_TBL_RD = 3'd3,
    WS_TBL_WB = 3'd4
  } walk_st_t;

  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_ABSENT = 2'd1,
    FC_PRIV   = 2'd2,
    FC_WPROT  = 2'd3
  } fault_code_t;

endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
  import pgwalk_pkg::*;
(
  input  logic        ent_present,
  input  logic        ent_write,
  input  logic        ent_user,
  input  logic        acc_user,
  input  logic        acc_write,
  output fault_code_t cause
);

  // priority: absent, then privilege, then write protection
  always_comb begin
    if (!ent_present)               cause = FC_ABSENT;
    else if (acc_user && !ent_user) cause = FC_PRIV;
    else if (acc_write && !ent_write) cause = FC_WPROT;
    else                            cause = FC_NONE;
  end

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic [VA_W-1:0]       va,
  input  logic [VA_W-OFF_W-1:0] base_frm,
  input  logic [VA_W-OFF_W-1:0] pde_frm,
  input  logic [VA_W-OFF_W-1:0] leaf_frm,
  output logic [VA_W-1:0]       dir_addr,
  output logic [VA_W-1:0]       tbl_addr,
  output logic [VA_W-1:0]       pa_small,
  output logic [VA_W-1:0]       pa_large
);

  localparam int unsigned FRM_W     = VA_W - OFF_W;
  localparam int unsigned ENT_SHIFT = OFF_W - IDX_W;
  localparam int unsigned BIG_OFF_W = OFF_W + IDX_W;
  localparam int unsigned DIR_LSB   = VA_W - IDX_W;

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;

  assign dir_idx = va[VA_W-1:DIR_LSB];
  assign tbl_idx = va[BIG_OFF_W-1:OFF_W];

  assign dir_addr = {base_frm, dir_idx, {ENT_SHIFT{1'b0}}};
  assign tbl_addr = {pde_frm,  tbl_idx, {ENT_SHIFT{1'b0}}};
  assign pa_small = {leaf_frm, va[OFF_W-1:0]};
  assign pa_large = {leaf_frm[FRM_W-1:IDX_W], va[BIG_OFF_W-1:0]};

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_write,
  input  logic                  req_user,
  input  logic [VA_W-OFF_W-1:0] dir_frame,
  input  logic                  mem_ack,
  input  logic [VA_W-1:0]       mem_rdata,
  input  fault_code_t           chk_cause,
  input  logic [VA_W-1:0]       dir_addr,
  input  logic [VA_W-1:0]       tbl_addr,
  input  logic [VA_W-1:0]       pa_small,
  input  logic [VA_W-1:0]       pa_large,
  output logic [VA_W-1:0]       va_q,
  output logic [VA_W-OFF_W-1:0] base_q,
  output logic [VA_W-1:0]       pde_q,
  output logic [VA_W-1:0]       leaf_ent,
  output logic                  user_q,
  output logic                  write_q,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output fault_code_t           fault_cause,
  output logic [VA_W-1:0]       pa,
  output logic [VA_W-1:0]       leaf_entry,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [VA_W-1:0]       mem_addr,
  output logic [VA_W-1:0]       mem_wdata
);

  localparam logic [VA_W-1:0] ACC_MASK = VA_W'(1) << FLG_ACCESS;
  localparam logic [VA_W-1:0] DRT_MASK = VA_W'(1) << FLG_DIRTY;

  walk_st_t        st_q, st_d;
  logic [VA_W-1:0] pte_q;
  logic [VA_W-1:0] upd_dir, upd_tbl;
  logic            take_en, pde_en, pte_en, res_en;
  logic [VA_W-1:0] res_pa, res_leaf;
  logic            done_d, fault_d;
  fault_code_t     cause_d;

  assign upd_dir = mem_rdata | ACC_MASK;
  assign upd_tbl = mem_rdata | ACC_MASK | (write_q ? DRT_MASK : '0);

  // entry that becomes the leaf if the walk finishes this cycle
  always_comb begin
    unique case (st_q)
      WS_DIR_RD: leaf_ent = upd_dir;
      WS_DIR_WB: leaf_ent = pde_q;
      WS_TBL_RD: leaf_ent = upd_tbl;
      default:   leaf_ent = pte_q;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    take_en  = 1'b0;
    pde_en   = 1'b0;
    pte_en   = 1'b0;
    res_en   = 1'b0;
    res_pa   = '0;
    res_leaf = '0;
    done_d   = 1'b0;
    fault_d  = 1'b0;
    cause_d  = FC_NONE;
    unique case (st_q)
      WS_IDLE: begin
        if (req_valid) begin
          take_en = 1'b1;
          st_d    = WS_DIR_RD;
        end
      end
      WS_DIR_RD: begin
        if (mem_ack) begin
          if (chk_cause != FC_NONE) begin
            fault_d  = 1'b1;
            cause_d  = chk_cause;
            res_en   = 1'b1;
            res_leaf = mem_rdata;
            st_d     = WS_IDLE;
          end else begin
            pde_en = 1'b1;
            if (!mem_rdata[FLG_ACCESS]) begin
              st_d = WS_DIR_WB;
            end else if (mem_rdata[FLG_LARGE]) begin
              done_d   = 1'b1;
              res_en   = 1'b1;
              res_pa   = pa_large;
              res_leaf = leaf_ent;
              st_d     = WS_IDLE;
            end else begin
              st_d = WS_TBL_RD;
            end
          end
        end
      end
      WS_DIR_WB: begin
        if (mem_ack) begin
          if (pde_q[FLG_LARGE]) begin
            done_d   = 1'b1;
            res_en   = 1'b1;
            res_pa   = pa_large;
            res_leaf = leaf_ent;
            st_d     = WS_IDLE;
          end else begin
            st_d = WS_TBL_RD;
          end
        end
      end
      WS_TBL_RD: begin
        if (mem_ack) begin
          if (chk_cause != FC_NONE) begin
            fault_d  = 1'b1;
            cause_d  = chk_cause;
            res_en   = 1'b1;
            res_leaf = mem_rdata;
            st_d     = WS_IDLE;
          end else begin
            pte_en = 1'b1;
            if (upd_tbl != mem_rdata) begin
              st_d = WS_TBL_WB;
            end else begin
              done_d   = 1'b1;
              res_en   = 1'b1;
              res_pa   = pa_small;
              res_leaf = leaf_ent;
              st_d     = WS_IDLE;
            end
          end
        end
      end
      WS_TBL_WB: begin
        if (mem_ack) begin
          done_d   = 1'b1;
          res_en   = 1'b1;
          res_pa   = pa_small;
          res_leaf = leaf_ent;
          st_d     = WS_IDLE;
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= WS_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      user_q      <= 1'b0;
      write_q     <= 1'b0;
      pde_q       <= '0;
      pte_q       <= '0;
      pa          <= '0;
      leaf_entry  <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= FC_NONE;
    end else begin
      st_q        <= st_d;
      done        <= done_d;
      fault       <= fault_d;
      fault_cause <= cause_d;
      if (take_en) begin
        va_q    <= req_vaddr;
        base_q  <= dir_frame;
        user_q  <= req_user;
        write_q <= req_write;
      end
      if (pde_en) pde_q <= upd_dir;
      if (pte_en) pte_q <= upd_tbl;
      if (res_en) begin
        pa         <= res_pa;
        leaf_entry <= res_leaf;
      end
    end
  end

  // memory port, held by state until acknowledged
  assign busy      = (st_q != WS_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st_q == WS_DIR_WB) || (st_q == WS_TBL_WB);
  assign mem_addr  = ((st_q == WS_DIR_RD) || (st_q == WS_DIR_WB)) ? dir_addr : tbl_addr;
  assign mem_wdata = (st_q == WS_DIR_WB) ? pde_q : pte_q;

endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_write,
  input  logic                  req_user,
  input  logic [VA_W-OFF_W-1:0] dir_frame,
  output logic                  busy,
  output logic                  done,
  output logic                  fault,
  output logic [1:0]            fault_cause,
  output logic [VA_W-1:0]       pa,
  output logic [VA_W-1:0]       leaf_entry,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [VA_W-1:0]       mem_addr,
  output logic [VA_W-1:0]       mem_wdata,
  input  logic                  mem_ack,
  input  logic [VA_W-1:0]       mem_rdata
);

  localparam int unsigned FRM_W = VA_W - OFF_W;

  // reset asserts at once, releases on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [VA_W-1:0]  va_q, pde_q, leaf_ent;
  logic [FRM_W-1:0] base_q;
  logic             user_q, write_q;
  logic [VA_W-1:0]  dir_addr, tbl_addr, pa_small, pa_large;
  fault_code_t      chk_cause, cause_q;

  pgwalk_perm u_perm (
    .ent_present (mem_rdata[FLG_PRESENT]),
    .ent_write   (mem_rdata[FLG_WRITE]),
    .ent_user    (mem_rdata[FLG_USER]),
    .acc_user    (user_q),
    .acc_write   (write_q),
    .cause       (chk_cause)
  );

  pgwalk_addr #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .va       (va_q),
    .base_frm (base_q),
    .pde_frm  (pde_q[VA_W-1:OFF_W]),
    .leaf_frm (leaf_ent[VA_W-1:OFF_W]),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr),
    .pa_small (pa_small),
    .pa_large (pa_large)
  );

  pgwalk_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .req_write   (req_write),
    .req_user    (req_user),
    .dir_frame   (dir_frame),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .chk_cause   (chk_cause),
    .dir_addr    (dir_addr),
    .tbl_addr    (tbl_addr),
    .pa_small    (pa_small),
    .pa_large    (pa_large),
    .va_q        (va_q),
    .base_q      (base_q),
    .pde_q       (pde_q),
    .leaf_ent    (leaf_ent),
    .user_q      (user_q),
    .write_q     (write_q),
    .busy        (busy),
    .done        (done),
    .fault       (fault),
    .fault_cause (cause_q),
    .pa          (pa),
    .leaf_entry  (leaf_entry),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );

  assign fault_cause = cause_q;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic [1:0]      fault_cause,
  input logic            mem_req,
  input logic            mem_we,
  input logic [VA_W-1:0] mem_addr,
  input logic [VA_W-1:0] mem_wdata,
  input logic            mem_ack
);

  AST_TAKE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && mem_ack == 1'b0) |=> (busy || !rst_n)) else $error("take");  // R10

  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!busy && !(done && fault))) else $error("end");  // R10

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))) else $error("hold");  // R11

  AST_END_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> $past(mem_ack)) else $error("ack");  // R11

  AST_CAUSE_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause != 2'd0) == fault) else $error("cause");  // R5

  AST_WB_HAS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]) else $error("acc");  // R8

endmodule

bind pgwalk pgwalk_chk #(.VA_W(VA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .fault_cause (fault_cause),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack)
);

// File: tb/sim_pgwalk.sv
`timescale 1ns/1ps
module sim_pgwalk;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [19:0] dir_frame = 20'hFEDC3;
  logic        busy, done, fault;
  logic [1:0]  fault_cause;
  logic [31:0] pa, leaf_entry;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pgwalk u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .dir_frame(dir_frame),
    .busy(busy), .done(done), .fault(fault), .fault_cause(fault_cause),
    .pa(pa), .leaf_entry(leaf_entry), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: 16 KB window, 0 or 1 wait cycles
  logic [31:0] mem [0:4095];
  int          wr_cnt = 0;
  int          rd_cnt = 0;
  logic        lat_sel = 1'b0;
  logic        lat_cnt = 1'b0;
  logic [31:0] held_addr = '0;

  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt && mem_addr !== held_addr) chk("R11 address held", mem_addr, held_addr);
      held_addr <= mem_addr;
      if (lat_cnt == lat_sel) begin
        mem_ack <= 1'b1;
        lat_cnt <= 1'b0;
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= mem[mem_addr[13:2]];
          rd_cnt <= rd_cnt + 1;
        end
      end else begin
        lat_cnt <= 1'b1;
      end
    end
  end

  function automatic logic [1:0] lvl(input logic [31:0] e, input logic u, input logic w);
    if (!e[0])          return 2'd1;
    if (u && !e[2])     return 2'd2;
    if (w && !e[1])     return 2'd3;
    return 2'd0;
  endfunction

  initial begin
    #(20 * 180000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R10 reset done/fault", {30'd0, done, fault}, 32'd0);
    chk("R5 reset cause", {30'd0, fault_cause}, 32'd0);
    chk("R11 reset mem_req", {31'd0, mem_req}, 32'd0);

    for (int n = 0; n < 4096; n++) begin
      logic [4:0]  pf, tf;
      logic        w, u;
      logic [9:0]  di, ti;
      logic [11:0] off;
      logic [31:0] va, pde, pte, e_dir, e_tbl, e_pa, e_leaf;
      logic [1:0]  c;
      int          e_rd, e_wr, rd0, wr0, cyc;
      pf  = n[4:0];
      tf  = n[9:5];
      w   = n[10];
      u   = n[11];
      di  = 10'((n * 37) % 1024);
      ti  = 10'((n * 91 + 5) % 1024);
      off = 12'((n * 13) % 4096);
      va  = {di, ti, off};
      pde = {12'(n * 3 + 1), 6'(n), 2'b01, 12'd0};
      pde[11:9] = n[7:5];  pde[3] = n[1];  pde[4] = n[3];  pde[6] = n[2];
      pde[0] = pf[0]; pde[1] = pf[1]; pde[2] = pf[2]; pde[5] = pf[3]; pde[7] = pf[4];
      pte = {20'(n * 2654435 + 17), 12'd0};
      pte[11:9] = n[10:8]; pte[3] = n[4]; pte[4] = n[0]; pte[7] = n[6];
      pte[0] = tf[0]; pte[1] = tf[1]; pte[2] = tf[2]; pte[5] = tf[3]; pte[6] = tf[4];
      mem[12'hC00 + 12'(di)] = pde;
      mem[12'h400 + 12'(ti)] = pte;

      // expected result from the requirements
      e_rd = 1; e_wr = 0; e_dir = pde; e_tbl = pte; e_pa = 32'd0;
      c = lvl(pde, u, w);
      e_leaf = pde;
      if (c == 2'd0) begin
        e_dir = pde | 32'h20;
        if (!pde[5]) e_wr++;
        if (pde[7]) begin
          e_leaf = e_dir;
          e_pa = {pde[31:22], va[21:0]};
        end else begin
          e_rd++;
          c = lvl(pte, u, w);
          e_leaf = pte;
          if (c == 2'd0) begin
            e_tbl = pte | 32'h20 | (w ? 32'h40 : 32'h0);
            if (e_tbl != pte) e_wr++;
            e_leaf = e_tbl;
            e_pa = {pte[31:12], off};
          end
        end
      end

      rd0 = rd_cnt; wr0 = wr_cnt;
      lat_sel   = n[1] ^ n[6];
      req_valid = 1'b1;
      req_vaddr = va;
      req_write = w;
      req_user  = u;
      @(negedge clk);
      chk("R10 busy after take", {31'd0, busy}, 32'd1);
      req_vaddr = ~va;
      req_write = ~w;
      req_user  = ~u;
      cyc = 0;
      while (!(done || fault) && cyc < 100) begin
        @(negedge clk);
        cyc++;
      end
      req_valid = 1'b0;
      chk("R10 busy low at end", {31'd0, busy}, 32'd0);
      chk("R10 outcome", {30'd0, done, fault}, {30'd0, c == 2'd0, c != 2'd0});
      if (c == 2'd1)      chk("R5 absent cause", {30'd0, fault_cause}, 32'd1);
      else if (c == 2'd2) chk("R6 user cause", {30'd0, fault_cause}, 32'd2);
      else if (c == 2'd3) chk("R7 write cause", {30'd0, fault_cause}, 32'd3);
      else                chk("R5 no cause", {30'd0, fault_cause}, 32'd0);
      if (pde[7] && c == 2'd0) chk("R4 large pa", pa, e_pa);
      else                     chk("R3 small pa", pa, e_pa);
      chk("R12 leaf entry", leaf_entry, e_leaf);
      chk("R4 read count", 32'(rd_cnt - rd0), 32'(e_rd));
      chk("R8 write count", 32'(wr_cnt - wr0), 32'(e_wr));
      chk("R1 directory word", mem[12'hC00 + 12'(di)], e_dir);
      chk("R2 R9 table word", mem[12'h400 + 12'(ti)], e_tbl);
      @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule